// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps wall-clock time and a calendar in seven byte-wide BCD registers: seconds, minutes, hours, date, month, day of week and year. It is clocked directly from a 32768 Hz time base. A free-running prescaler divides that clock down to a one-second tick, and each tick advances the seconds. Carries ripple through minutes, hours, date and month to the year. Month lengths and leap-year Februaries are applied automatically when the date rolls over.

A serial host front end outside this block reads any register through a combinational read port and writes any register through a single-cycle write strobe. The hour register holds its own 12/24-hour format bit. Its bit 5 has two meanings: in 12-hour format it is the PM flag, and in 24-hour format it is the upper tens-of-hours digit. The seconds register holds a halt flag that freezes the prescaler and all counting.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the registers read seconds 0x80 (halted, 00 s), minutes 0x00, hours 0x00 (24-hour, midnight), date 0x01, month 0x01, day of week 0x01 and year 0x00.
- R2: Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. Address 7 reads 0x00 and ignores writes. Bits with no meaning read 0: seconds bit 7 is the halt flag, minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and day bits 7:3.
- R3: While seconds bit 7 is 1, no register advances and the tick output stays low, however many clocks pass.
- R4: Any write to the seconds register clears the prescaler. With the halt flag written as 0, the seconds value first advances on the 2^PRESCALE_W-th clock edge after the write edge.
- R5: Seconds and minutes each count 00 to 59, wrap to 00 and carry into the next field.
- R6: With hours bit 7 = 0 (24-hour format), hours count 00 to 23. The 23 to 00 wrap advances the date and the day of week.
- R7: With hours bit 7 = 1 (12-hour format, bit 5 = PM), 11 advances to 12 and toggles bit 5, and 12 advances to 01. The date advances only on the PM 11 to AM 12 step.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 29 when the BCD year is a multiple of 4 and after 28 otherwise. In all other months it wraps after 31. The wrap advances the month.
- R9: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00. The day of week advances with each date step and wraps from 07 to 01.
- R10: A write to a register wins over that register's increment in the same cycle and suppresses the carry it would have produced.
- R11: While running, the tick output pulses for exactly one clock in every 2^PRESCALE_W clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32768 Hz time base |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 8 | Write data (BCD) |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| sec_tick_o | output | 1 | One-second tick, high for one clock |

## Verification
A write lands on the clock edge that samples it, and the read port is combinational, so the bench reads back written values one clock later. After a seconds write, the first increment lands exactly 2^PRESCALE_W edges later. The bench therefore samples once after 2^PRESCALE_W - 1 edges, when the old value must still hold, and once after the next edge. A carry from seconds to the year completes on the same edge as the seconds wrap, so every rollover check reads all fields one full tick period after the write. All inputs are driven and all outputs sampled at the falling edge. The bench runs with a 4-bit prescaler so that each second is 16 clocks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    REG_SEC   = 3'd0,
    REG_MIN   = 3'd1,
    REG_HOUR  = 3'd2,
    REG_DATE  = 3'd3,
    REG_MONTH = 3'd4,
    REG_WDAY  = 3'd5,
    REG_YEAR  = 3'd6
  } rtc_reg_e;

  localparam int NUM_REGS = 7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] b;
    b = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
    return (b % 8'd4) == 8'd0;
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (&cnt_q);
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [7:0] RST  = 8'h00,
  parameter logic [7:0] LO   = 8'h00,
  parameter logic [7:0] MASK = 8'hff
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] max_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  logic [7:0] val_q;
  logic       wrap;

  assign wrap    = val_q >= max_i;
  assign carry_o = inc_i && !wr_i && wrap;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= RST;
    else if (wr_i)  val_q <= wr_data_i & MASK;
    else if (inc_i) val_q <= wrap ? LO : bcd_inc(val_q);
  end
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] hour_o,
  output logic       carry_o
);
  logic [7:0] hr_q, hr_nx;
  logic       day_step;
  logic       lo_wrap;
  logic [3:0] lo_inc;

  assign lo_wrap = hr_q[3:0] == 4'd9;
  assign lo_inc  = lo_wrap ? 4'd0 : hr_q[3:0] + 4'd1;

  always_comb begin
    hr_nx    = hr_q;
    day_step = 1'b0;
    if (hr_q[7]) begin
      // 12-hour: bit 5 is PM
      if (hr_q[4:0] == 5'h12) begin
        hr_nx[4:0] = 5'h01;
      end else if (hr_q[4:0] == 5'h11) begin
        hr_nx[4:0] = 5'h12;
        hr_nx[5]   = ~hr_q[5];
        day_step   = hr_q[5];
      end else begin
        hr_nx[4]   = hr_q[4] | lo_wrap;
        hr_nx[3:0] = lo_inc;
      end
    end else begin
      if (hr_q[5:0] == 6'h23) begin
        hr_nx[5:0] = 6'h00;
        day_step   = 1'b1;
      end else begin
        hr_nx[5:4] = hr_q[5:4] + {1'b0, lo_wrap};
        hr_nx[3:0] = lo_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hr_q <= 8'h00;
    else if (wr_i)  hr_q <= wr_data_i & 8'hbf;
    else if (inc_i) hr_q <= hr_nx;
  end

  assign hour_o  = hr_q;
  assign carry_o = inc_i && !wr_i && day_step;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       sec_tick_o
);
  logic [NUM_REGS-1:0] wr_sel;
  logic       ch_q;
  logic [7:0] sec_val, min_val, hour_val, date_val, month_val, wday_val, year_val;
  logic       sec_cy, min_cy, hour_cy, date_cy, month_cy, wday_cy, year_cy;
  logic [7:0] date_max;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
    assign wr_sel[i] = wr_en_i && (wr_addr_i == 3'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ch_q <= 1'b1;
    else if (wr_sel[REG_SEC]) ch_q <= wr_data_i[7];
  end

  rtc_prescaler #(.W(PRESCALE_W)) u_presc (
    .clk_i, .rst_ni,
    .run_i (!ch_q),
    .clr_i (wr_sel[REG_SEC]),
    .tick_o(sec_tick_o)
  );

  rtc_bcd_field #(.RST(8'h00), .LO(8'h00), .MASK(8'h7f)) u_sec (
    .clk_i, .rst_ni, .inc_i(sec_tick_o), .wr_i(wr_sel[REG_SEC]), .wr_data_i,
    .max_i(8'h59), .val_o(sec_val), .carry_o(sec_cy));

  rtc_bcd_field #(.RST(8'h00), .LO(8'h00), .MASK(8'h7f)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_cy), .wr_i(wr_sel[REG_MIN]), .wr_data_i,
    .max_i(8'h59), .val_o(min_val), .carry_o(min_cy));

  rtc_hour_unit u_hour (
    .clk_i, .rst_ni, .inc_i(min_cy), .wr_i(wr_sel[REG_HOUR]), .wr_data_i,
    .hour_o(hour_val), .carry_o(hour_cy));

  assign date_max = month_days(month_val, is_leap(year_val));

  rtc_bcd_field #(.RST(8'h01), .LO(8'h01), .MASK(8'h3f)) u_date (
    .clk_i, .rst_ni, .inc_i(hour_cy), .wr_i(wr_sel[REG_DATE]), .wr_data_i,
    .max_i(date_max), .val_o(date_val), .carry_o(date_cy));

  rtc_bcd_field #(.RST(8'h01), .LO(8'h01), .MASK(8'h1f)) u_month (
    .clk_i, .rst_ni, .inc_i(date_cy), .wr_i(wr_sel[REG_MONTH]), .wr_data_i,
    .max_i(8'h12), .val_o(month_val), .carry_o(month_cy));

  rtc_bcd_field #(.RST(8'h01), .LO(8'h01), .MASK(8'h07)) u_wday (
    .clk_i, .rst_ni, .inc_i(hour_cy), .wr_i(wr_sel[REG_WDAY]), .wr_data_i,
    .max_i(8'h07), .val_o(wday_val), .carry_o(wday_cy));

  rtc_bcd_field #(.RST(8'h00), .LO(8'h00), .MASK(8'hff)) u_year (
    .clk_i, .rst_ni, .inc_i(month_cy), .wr_i(wr_sel[REG_YEAR]), .wr_data_i,
    .max_i(8'h99), .val_o(year_val), .carry_o(year_cy));

  always_comb begin
    case (rd_addr_i)
      REG_SEC:   rd_data_o = {ch_q, sec_val[6:0]};
      REG_MIN:   rd_data_o = min_val;
      REG_HOUR:  rd_data_o = hour_val;
      REG_DATE:  rd_data_o = date_val;
      REG_MONTH: rd_data_o = month_val;
      REG_WDAY:  rd_data_o = wday_val;
      REG_YEAR:  rd_data_o = year_val;
      default:   rd_data_o = 8'h00;
    endcase
  end

  // wday and year carries have no consumer
  logic unused_cy;
  assign unused_cy = wday_cy ^ year_cy ^ sec_val[7];
endmodule

// File: rtl/rtc_calendar_core_checker.sv
module rtc_calendar_core_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       sec_tick_o,
  input logic       ch_q,
  input logic [7:0] sec_val,
  input logic [7:0] min_val,
  input logic [7:0] hour_val
);
  logic wr_sec, wr_min;
  assign wr_sec = wr_en_i && (wr_addr_i == 3'd0);
  assign wr_min = wr_en_i && (wr_addr_i == 3'd1);

  assert_halt_freezes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_q && !wr_sec) |=> (sec_val == $past(sec_val)));

  assert_sec_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sec |=> (sec_val == ($past(wr_data_i) & 8'h7f)));

  assert_min_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_min |=> (min_val == ($past(wr_data_i) & 8'h7f)));

  assert_tick_advances_sec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_o && !wr_sec) |=> (sec_val != $past(sec_val)));

  assert_sec_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_val[3:0] <= 4'd9) && (sec_val[6:4] <= 3'd5));

  assert_hour12_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_val[7] |-> (hour_val[4:0] != 5'h00));

  assert_single_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);
endmodule

bind rtc_calendar_core rtc_calendar_core_checker u_checker (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .sec_tick_o,
  .ch_q(ch_q), .sec_val(sec_val), .min_val(min_val), .hour_val(hour_val)
);

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
module rtc_calendar_core_bench;
  localparam int PW  = 4;
  localparam int SEC = 1 << PW;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       sec_tick_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  rtc_calendar_core #(.PRESCALE_W(PW)) u_rtc_calendar_core (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .sec_tick_o);

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr_i = a;
    #1;
    n_chk++;
    if (rd_data_o !== exp) begin
      n_fail++;
      $display("FAIL %s reg %0d: actual %h expected %h", req, a, rd_data_o, exp);
    end
  endtask

  task automatic chk_ticks(input string req, input int exp);
    int cnt = 0;
    for (int i = 0; i < 4 * SEC; i++) begin
      @(negedge clk_i);
      if (sec_tick_o) cnt++;
    end
    n_chk++;
    if (cnt != exp) begin
      n_fail++;
      $display("FAIL %s tick count: actual %0d expected %0d", req, cnt, exp);
    end
  endtask

  // halt, load all fields, start at sec s; returns just after the start write
  task automatic load(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                      input logic [7:0] d, input logic [7:0] mo, input logic [7:0] wd,
                      input logic [7:0] y);
    wr(3'd0, 8'h80);
    wr(3'd1, mi); wr(3'd2, h); wr(3'd3, d); wr(3'd4, mo); wr(3'd5, wd); wr(3'd6, y);
    wr(3'd0, s);
  endtask

  task automatic roll(input string req, input logic [7:0] h, input logic [7:0] d,
                      input logic [7:0] mo, input logic [7:0] wd, input logic [7:0] y,
                      input logic [7:0] eh, input logic [7:0] ed, input logic [7:0] emo,
                      input logic [7:0] ewd, input logic [7:0] ey);
    load(h, 8'h59, 8'h59, d, mo, wd, y);
    step(SEC);
    chk(req, 3'd0, 8'h00); chk(req, 3'd1, 8'h00); chk(req, 3'd2, eh);
    chk(req, 3'd3, ed);    chk(req, 3'd4, emo);   chk(req, 3'd5, ewd);
    chk(req, 3'd6, ey);
    wr(3'd0, 8'h80);
  endtask

  task automatic t_reset();
    chk("R1", 3'd0, 8'h80); chk("R1", 3'd1, 8'h00); chk("R1", 3'd2, 8'h00);
    chk("R1", 3'd3, 8'h01); chk("R1", 3'd4, 8'h01); chk("R1", 3'd5, 8'h01);
    chk("R1", 3'd6, 8'h00);
  endtask

  task automatic t_map();
    wr(3'd7, 8'h55); chk("R2", 3'd7, 8'h00);
    wr(3'd3, 8'hc5); chk("R2", 3'd3, 8'h05);
    wr(3'd5, 8'hf3); chk("R2", 3'd5, 8'h03);
    wr(3'd4, 8'he9); chk("R2", 3'd4, 8'h09);
    wr(3'd2, 8'h61); chk("R2", 3'd2, 8'h21);
    wr(3'd1, 8'hc4); chk("R2", 3'd1, 8'h44);
  endtask

  task automatic t_halt_and_tick();
    wr(3'd0, 8'h85);
    step(100);
    chk("R3", 3'd0, 8'h85);
    chk_ticks("R3", 0);
    chk("R3", 3'd0, 8'h85);
    wr(3'd0, 8'h05);
    chk_ticks("R11", 4);
    chk("R11", 3'd0, 8'h09);
    wr(3'd0, 8'h80);
  endtask

  task automatic t_first_tick();
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h58);
    step(SEC - 1); chk("R4", 3'd0, 8'h58);
    step(1);       chk("R4", 3'd0, 8'h59);
    step(SEC);     chk("R5", 3'd0, 8'h00);
    chk("R5", 3'd1, 8'h08);
    wr(3'd0, 8'h80);
  endtask

  task automatic t_write_priority();
    wr(3'd1, 8'h10); wr(3'd2, 8'h05);
    wr(3'd0, 8'h59);
    step(SEC - 1);
    wr(3'd1, 8'h42);   // lands on the tick edge
    chk("R10", 3'd0, 8'h00);
    chk("R10", 3'd1, 8'h42);
    chk("R10", 3'd2, 8'h05);
    wr(3'd0, 8'h80);
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_map();
    t_halt_and_tick();
    t_first_tick();
    t_write_priority();
    roll("R6", 8'h23, 8'h15, 8'h06, 8'h03, 8'h25, 8'h00, 8'h16, 8'h06, 8'h04, 8'h25);
    roll("R6", 8'h09, 8'h15, 8'h06, 8'h03, 8'h25, 8'h10, 8'h15, 8'h06, 8'h03, 8'h25);
    roll("R7", 8'h91, 8'h10, 8'h06, 8'h02, 8'h25, 8'hb2, 8'h10, 8'h06, 8'h02, 8'h25);
    roll("R7", 8'hb1, 8'h10, 8'h06, 8'h02, 8'h25, 8'h92, 8'h11, 8'h06, 8'h03, 8'h25);
    roll("R7", 8'hb2, 8'h10, 8'h06, 8'h02, 8'h25, 8'ha1, 8'h10, 8'h06, 8'h02, 8'h25);
    roll("R7", 8'h89, 8'h10, 8'h06, 8'h02, 8'h25, 8'h90, 8'h10, 8'h06, 8'h02, 8'h25);
    roll("R8", 8'h23, 8'h30, 8'h04, 8'h01, 8'h25, 8'h00, 8'h01, 8'h05, 8'h02, 8'h25);
    roll("R8", 8'h23, 8'h30, 8'h05, 8'h01, 8'h25, 8'h00, 8'h31, 8'h05, 8'h02, 8'h25);
    roll("R8", 8'h23, 8'h28, 8'h02, 8'h01, 8'h23, 8'h00, 8'h01, 8'h03, 8'h02, 8'h23);
    roll("R8", 8'h23, 8'h28, 8'h02, 8'h01, 8'h24, 8'h00, 8'h29, 8'h02, 8'h02, 8'h24);
    roll("R8", 8'h23, 8'h29, 8'h02, 8'h01, 8'h24, 8'h00, 8'h01, 8'h03, 8'h02, 8'h24);
    roll("R8", 8'h23, 8'h28, 8'h02, 8'h01, 8'h00, 8'h00, 8'h29, 8'h02, 8'h02, 8'h00);
    roll("R8", 8'h23, 8'h31, 8'h01, 8'h01, 8'h25, 8'h00, 8'h01, 8'h02, 8'h02, 8'h25);
    roll("R9", 8'h23, 8'h31, 8'h12, 8'h07, 8'h99, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    roll("R9", 8'h23, 8'h31, 8'h12, 8'h05, 8'h19, 8'h00, 8'h01, 8'h01, 8'h06, 8'h20);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule